// File: doc/BRIEF.md
# Iterative Half-Subtractor Parallel Subtractor

This block subtracts one 16-bit unsigned operand from another without a rippling full-subtractor chain. Every bit position holds one half subtractor fed by a two-input multiplexer. On the first pass the multiplexers present the minuend and subtrahend bits. Each later pass instead presents the bit's own previous difference and the borrow raised one position below. Passes repeat, one per clock, until no bit raises a borrow. The registered difference then equals the modulo-2^16 result. A borrow pushed out of the top bit at any pass sets a sticky flag, which shows that the minuend was smaller than the subtrahend.

A small state machine drives the passes. After reset it sits in IDLE. A high request moves it to SPIN (transition START) and loads the operand pass in the same edge. In SPIN it does one feedback pass per clock (transition STEP) while any borrow is pending. When the borrow vector is all zero it moves to HOLD (transition SETTLE), and done rises there. HOLD holds the result for as long as the request stays high. A low request returns the machine to IDLE from SPIN (transition ABORT) or from HOLD (transition RELEASE). The operands are sampled only on the START edge.

Top module: `iter_half_subtractor`

## Requirements
- R1: While reset is held low and on the first clock after its release, done, borrow_out and diff are all zero.
- R2: When no bit has a subtrahend of 1 over a minuend of 0, the first pass produces no borrow. Done then rises exactly 2 clocks after the request is first sampled high, with diff equal to minuend XOR subtrahend.
- R3: When done is high, diff equals (minuend − subtrahend) modulo 2^16, using the operands sampled on the START edge.
- R4: When done is high, borrow_out is 1 exactly when the minuend is less than the subtrahend as unsigned numbers, and 0 otherwise.
- R5: While the request stays high in HOLD, done stays high and diff and borrow_out do not change.
- R6: One clock after the request is sampled low, done is low.
- R7: Done rises no later than WIDTH+2 clocks after the request is first sampled high. For minuend 0x0000 and subtrahend 0x0001 it rises after exactly 18 clocks.
- R8: Operand changes after the START edge have no effect on diff or borrow_out.
- R9: No bit ever holds the pair (borrow 1, difference 0) in its registers.
- R10: If the request drops while SPIN is still running, the pass is abandoned, done stays low, and a later request computes a correct fresh result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one subtraction pass per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request; rising level starts a subtraction, low level releases it |
| minuend | input | 16 | Value subtracted from |
| subtrahend | input | 16 | Value subtracted |
| diff | output | 16 | Modulo-2^16 difference, valid while done is high |
| borrow_out | output | 1 | Set when any borrow left the top bit, which marks a negative result |
| done | output | 1 | High once all borrows are zero, until the request drops |

## Verification
A wrong borrow vector inside the loop shows at the ports in one of two ways. It keeps SPIN running past the WIDTH+2 bound, or it ends with a diff or borrow_out that differs from the arithmetic result. Either fault appears within 18 clocks of the request. A wrong state decode shows as a done that rises too early on the no-borrow vectors, which have an exact 2-clock latency. It also shows as a done that does not follow the request low on the next clock. The internal pair invariant is watched on every clock, so a broken half subtractor is flagged in the cycle it writes the register.

// File: rtl/ihs_pkg.sv
package ihs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SPIN = 2'd1,
        ST_HOLD = 2'd2
    } ihs_state_t;
endpackage

// File: rtl/ihs_cell.sv
module ihs_cell (
    input  logic sel,
    input  logic op_x,
    input  logic op_y,
    input  logic fb_d,
    input  logic fb_b,
    output logic nd,
    output logic nb
);
    logic a_in;
    logic b_in;

    always_comb begin
        a_in = sel ? fb_d : op_x;
        b_in = sel ? fb_b : op_y;
        nd   = a_in ^ b_in;
        nb   = ~a_in & b_in;
    end
endmodule

// File: rtl/ihs_ctrl.sv
module ihs_ctrl
    import ihs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic borrow_any,
    output logic sel,
    output logic load_en,
    output logic done
);
    ihs_state_t state_q;
    ihs_state_t state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_n = ST_SPIN;
            ST_SPIN: begin
                if (!req)             state_n = ST_IDLE;
                else if (!borrow_any) state_n = ST_HOLD;
            end
            ST_HOLD: if (!req) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        sel     = 1'b0;
        load_en = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: load_en = req;
            ST_SPIN: begin
                sel     = 1'b1;
                load_en = req & borrow_any;
            end
            ST_HOLD: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ihs_datapath.sv
module ihs_datapath #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             load_en,
    input  logic [WIDTH-1:0] op_x,
    input  logic [WIDTH-1:0] op_y,
    output logic [WIDTH-1:0] diff_q,
    output logic [WIDTH-1:0] brw_q,
    output logic             bout_q,
    output logic             borrow_any
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] nd_vec;
    logic [WIDTH-1:0] nb_vec;
    logic [WIDTH-1:0] fb_bin;

    assign fb_bin     = {brw_q[TOP-1:0], 1'b0};
    assign borrow_any = |brw_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        ihs_cell u_cell (
            .sel  (sel),
            .op_x (op_x[i]),
            .op_y (op_y[i]),
            .fb_d (diff_q[i]),
            .fb_b (fb_bin[i]),
            .nd   (nd_vec[i]),
            .nb   (nb_vec[i])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            diff_q <= '0;
            brw_q  <= '0;
            bout_q <= 1'b0;
        end else if (load_en) begin
            diff_q <= nd_vec;
            brw_q  <= nb_vec;
            bout_q <= sel ? (bout_q | brw_q[TOP]) : 1'b0;
        end
    end
endmodule

// File: rtl/iter_half_subtractor.sv
module iter_half_subtractor #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [WIDTH-1:0] minuend,
    input  logic [WIDTH-1:0] subtrahend,
    output logic [WIDTH-1:0] diff,
    output logic             borrow_out,
    output logic             done
);
    logic             sel;
    logic             load_en;
    logic             borrow_any;
    logic [WIDTH-1:0] brw_vec;

    ihs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .borrow_any (borrow_any),
        .sel        (sel),
        .load_en    (load_en),
        .done       (done)
    );

    ihs_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .load_en    (load_en),
        .op_x       (minuend),
        .op_y       (subtrahend),
        .diff_q     (diff),
        .brw_q      (brw_vec),
        .bout_q     (borrow_out),
        .borrow_any (borrow_any)
    );
endmodule

// File: rtl/ihs_checker.sv
module ihs_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             done,
    input logic             borrow_out,
    input logic [WIDTH-1:0] diff_q,
    input logic [WIDTH-1:0] brw_q
);
    logic [7:0] busy_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !req) busy_cnt <= '0;
        else if (!done)     busy_cnt <= busy_cnt + 8'd1;
    end

    p_pair_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (brw_q & ~diff_q) == '0);

    p_done_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (brw_q == '0));

    p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> (done && $stable(diff_q) && $stable(borrow_out)));

    p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !done);

    p_latency_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_cnt <= 8'(WIDTH + 2));
endmodule

bind iter_half_subtractor ihs_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .done       (done),
    .borrow_out (borrow_out),
    .diff_q     (diff),
    .brw_q      (brw_vec)
);

// File: tb/iter_half_subtractor_test.sv
`timescale 1ns/1ps
module iter_half_subtractor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [15:0] minuend = '0;
    logic [15:0] subtrahend = '0;
    logic [15:0] diff;
    logic        borrow_out;
    logic        done;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    iter_half_subtractor uut (
        .clk(clk), .rst_n(rst_n), .req(req),
        .minuend(minuend), .subtrahend(subtrahend),
        .diff(diff), .borrow_out(borrow_out), .done(done)
    );

    localparam logic [31:0] VEC [12] = '{
        {16'h0000, 16'h0001}, {16'h1234, 16'h0034}, {16'hFFFF, 16'h0001},
        {16'h0001, 16'hFFFF}, {16'h8000, 16'h0001}, {16'hAAAA, 16'h5555},
        {16'h5555, 16'hAAAA}, {16'h0000, 16'h0000}, {16'hFFFF, 16'hFFFF},
        {16'h7FFF, 16'h8000}, {16'h0100, 16'h00FF}, {16'hC3A5, 16'h3C5A}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] x, input logic [15:0] y, output int cyc);
        @(negedge clk);
        minuend = x; subtrahend = y; req = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            minuend = ~x; subtrahend = x ^ y;   // R8: scramble after START
        end while (!done && cyc < 40);
    endtask

    task automatic release_req();
        req = 1'b0;
        @(negedge clk);
        check("R6 done low after release", {31'd0, done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        check("R1 reset done", {31'd0, done}, 32'd0);
        check("R1 reset diff/bout", {15'd0, borrow_out, diff}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset idle", {15'd0, borrow_out, done, diff}, 32'd0);

        // Vector walk: R3, R4, R7, R8; R9 watched by the checker on every pass
        for (int i = 0; i < 12; i++) begin
            logic [15:0] x, y;
            x = VEC[i][31:16]; y = VEC[i][15:0];
            run_op(x, y, cyc);
            check("R7 done reached", {31'd0, done}, 32'd1);
            check("R7 latency bound", {31'd0, cyc <= 18}, 32'd1);
            if ((y & ~x) == 16'h0)
                check("R2 no-borrow latency", cyc, 32'd2);
            check("R3 R8 difference", {16'd0, diff}, {16'd0, x - y});
            check("R4 borrow flag", {31'd0, borrow_out}, {31'd0, x < y});
            @(negedge clk);
            check("R5 hold", {15'd0, done, diff}, {15'd0, 1'b1, x - y});
            release_req();
        end

        run_op(16'h0000, 16'h0001, cyc);
        check("R7 exact worst latency", cyc, 32'd18);
        release_req();

        run_op(16'h00F0, 16'h0030, cyc);
        check("R2 xor result", {16'd0, diff}, {16'd0, 16'h00F0 ^ 16'h0030});
        check("R2 latency", cyc, 32'd2);
        release_req();

        // R10: abort mid-run, then a fresh request
        @(negedge clk);
        minuend = 16'h0000; subtrahend = 16'h0001; req = 1'b1;
        repeat (4) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check("R10 abort keeps done low", {31'd0, done}, 32'd0);
        repeat (20) @(negedge clk);
        check("R10 idle after abort", {31'd0, done}, 32'd0);
        run_op(16'h4000, 16'h4001, cyc);
        check("R10 fresh diff", {15'd0, borrow_out, diff}, {15'd0, 1'b1, 16'hFFFF});
        release_req();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule